// File: doc/BRIEF.md
# Low-Voltage Backup Mode Controller

This block holds a small microcontroller in a low-power backup state whenever its supply or its external reset pin says it is unsafe to run. It runs on an always-on, low-speed sampling clock that keeps running while the main oscillator is stopped. It watches two asynchronous inputs. The first is a supply-good flag from an analog voltage detector, high when the supply is at or above threshold. The second is the active-low external reset pin. From these it drives an oscillator enable, a system-reset pulse and a backup status flag.

Backup is entered on a falling edge of the synchronized supply-good flag or when the debounced reset pin reads low. The oscillator is switched off while in backup. The only way out is a system reset. That reset is issued once the supply-good flag and the debounced pin are both high. The reset pulse has a fixed, parameterized width, and the oscillator is switched back on for its whole length. Interrupt wake requests are blocked while in backup, and so are watchdog reset requests. Outside backup, a watchdog request produces the same reset pulse.

The block starts in backup after its own power-on reset. The first time the supply becomes good with the pin high, it therefore produces the initial system reset.

Top module: `lvbk_ctrl`

## Requirements
- R1: During and directly after `rst_n` low, `backup_o`=1, `osc_en_o`=0, `sys_rst_o`=0 and `irq_wake_o`=0.
- R2: The pin filter accepts a new level of `ext_rst_n_i` only after 4 consecutive samples of that level. A low glitch of 3 samples has no effect. A pin change held at the input reaches the state 7 clock cycles after it is applied: 2 synchronizer stages, 4 filter samples and 1 state update.
- R3: Outside backup, a falling edge of `lv_ok_i` puts the block into backup on the 3rd clock edge after the input changes.
- R4: While `backup_o` is 1, `osc_en_o` is 0.
- R5: `irq_wake_o` follows `irq_req_i` outside backup and is 0 while `backup_o` is 1.
- R6: In backup, `wdt_req_i` never starts a reset pulse. In normal run, `wdt_req_i` high at a clock edge starts a reset pulse on that edge, and `osc_en_o` stays 1.
- R7: Release needs the synchronized supply flag and the filtered pin to be high together. If only one of them rises while the other is still low, the block stays in backup.
- R8: On release, `backup_o` falls and, in the same cycle, `sys_rst_o` and `osc_en_o` rise. `sys_rst_o` stays high for exactly 16 cycles, after which the block is in normal run (`backup_o`=0, `osc_en_o`=1, `sys_rst_o`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on low-speed sampling clock |
| rst_n | input | 1 | Synchronous active-low power-on reset of this logic |
| lv_ok_i | input | 1 | Asynchronous supply-good flag, 1 = supply at or above threshold |
| ext_rst_n_i | input | 1 | Asynchronous external reset pin, active low |
| irq_req_i | input | 1 | Interrupt wake request |
| wdt_req_i | input | 1 | Watchdog reset request, synchronous to `clk` |
| osc_en_o | output | 1 | Main oscillator enable |
| sys_rst_o | output | 1 | System reset pulse, active high |
| backup_o | output | 1 | 1 while backup mode is active |
| irq_wake_o | output | 1 | Gated interrupt wake request |

## Verification
A wrong state register shows up at once on `backup_o` and `osc_en_o`, because both are decoded directly from the state. A lost or extra supply edge changes these outputs three cycles after the input change. A miscounting pin filter moves the same edge away from the seventh cycle, or lets a three-sample glitch through. A faulty width counter is visible at the end of each reset pulse as a width other than sixteen. A leak in the gating shows as `irq_wake_o` or `sys_rst_o` going high while `backup_o` is set.

// File: rtl/lvbk_pkg.sv
// Shared types for the low-voltage backup controller.
package lvbk_pkg;
    // Controller states: parked, issuing reset pulse, running normally.
    typedef enum logic [1:0] {
        ST_BACKUP = 2'd0,
        ST_PULSE  = 2'd1,
        ST_RUN    = 2'd2
    } lvbk_state_t;
endpackage

// File: rtl/lvbk_sync.sv
// Two-flop synchronizer, one chain per bit.
// Assumes: inputs are asynchronous level signals; reset value given per bit.
module lvbk_sync #(
    parameter int          W        = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic s1, s2;
        // Two stages of metastability settling for bit b.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= RST_VAL[b];
                s2 <= RST_VAL[b];
            end else begin
                s1 <= d_i[b];
                s2 <= s1;
            end
        end
        assign q_o[b] = s2;
    end
endmodule

// File: rtl/lvbk_deglitch.sv
// Digital noise filter: output takes a new input level only after that
// level was seen on STABLE consecutive clock samples.
// Assumes: input already synchronized to clk.
module lvbk_deglitch #(
    parameter int   STABLE  = 4,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    localparam int CW = $clog2(STABLE + 1);
    localparam logic [CW-1:0] LAST = CW'(STABLE - 1);

    logic [CW-1:0] run_cnt;

    // Count samples that disagree with the held level; accept at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o     <= RST_VAL;
            run_cnt <= '0;
        end else if (d_i == q_o) begin
            run_cnt <= '0;
        end else if (run_cnt == LAST) begin
            q_o     <= d_i;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lvbk_pulse_timer.sv
// Width timer for the reset pulse: counts while run_i is high and flags
// the last cycle of a LEN-cycle window. Clears whenever run_i is low.
module lvbk_pulse_timer #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic last_o
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] cnt;

    // Advance during the pulse, hold at the end, clear outside it.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last_o = run_i && (cnt == LAST);
endmodule

// File: rtl/lvbk_ctrl.sv
// Low-voltage backup mode controller (top).
// Enters backup on a falling supply-good edge or a filtered low reset pin,
// stops the oscillator there, blocks interrupt and watchdog wake, and
// leaves only through a fixed-width system reset pulse once both supply
// and pin are good. Assumes clk is an always-on sampling clock and
// wdt_req_i / irq_req_i are synchronous to it.
module lvbk_ctrl #(
    parameter int FILT_SAMPLES = 4,
    parameter int PULSE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lv_ok_i,
    input  logic ext_rst_n_i,
    input  logic irq_req_i,
    input  logic wdt_req_i,
    output logic osc_en_o,
    output logic sys_rst_o,
    output logic backup_o,
    output logic irq_wake_o
);
    import lvbk_pkg::*;

    logic [1:0]  sync_q;
    logic        lv_sync;
    logic        pin_sync;
    logic        pin_ok;
    logic        lv_prev;
    logic        lv_fall;
    logic        pulse_last;
    logic        go_fail;
    lvbk_state_t state, state_nxt;

    lvbk_sync #(.W(2), .RST_VAL(2'b00)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({ext_rst_n_i, lv_ok_i}),
        .q_o   (sync_q)
    );
    assign lv_sync  = sync_q[0];
    assign pin_sync = sync_q[1];

    lvbk_deglitch #(.STABLE(FILT_SAMPLES), .RST_VAL(1'b0)) u_pin_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_sync),
        .q_o   (pin_ok)
    );

    lvbk_pulse_timer #(.LEN(PULSE_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state == ST_PULSE),
        .last_o (pulse_last)
    );

    // Previous supply-flag sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lv_prev <= 1'b0;
        else        lv_prev <= lv_sync;
    end

    assign lv_fall = lv_prev && !lv_sync;
    assign go_fail = lv_fall || !pin_ok;

    // Next-state choice: park, pulse, or run.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_BACKUP: if (lv_sync && pin_ok) state_nxt = ST_PULSE;
            ST_PULSE: begin
                if (go_fail)         state_nxt = ST_BACKUP;
                else if (pulse_last) state_nxt = ST_RUN;
            end
            ST_RUN: begin
                if (go_fail)        state_nxt = ST_BACKUP;
                else if (wdt_req_i) state_nxt = ST_PULSE;
            end
            default: state_nxt = ST_BACKUP;
        endcase
    end

    // State register; power-on lands in backup.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_BACKUP;
        else        state <= state_nxt;
    end

    assign backup_o   = (state == ST_BACKUP);
    assign osc_en_o   = (state != ST_BACKUP);
    assign sys_rst_o  = (state == ST_PULSE);
    assign irq_wake_o = irq_req_i && (state != ST_BACKUP);
endmodule

// File: rtl/lvbk_ctrl_chk.sv
// Property checker for lvbk_ctrl, attached by bind below.
module lvbk_ctrl_chk #(
    parameter int PULSE_CYCLES = 16
) (
    input logic clk,
    input logic rst_n,
    input logic lv_sync,
    input logic pin_ok,
    input logic wdt_req_i,
    input logic osc_en_o,
    input logic sys_rst_o,
    input logic backup_o,
    input logic irq_wake_o
);
    localparam int CW = $clog2(PULSE_CYCLES + 2);
    logic [CW-1:0] hi_cnt;

    // Length of the current reset pulse so far.
    always_ff @(posedge clk) begin
        if (!rst_n)         hi_cnt <= '0;
        else if (sys_rst_o) hi_cnt <= hi_cnt + 1'b1;
        else                hi_cnt <= '0;
    end

    // R4
    osc_off_in_backup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        backup_o |-> !osc_en_o);

    // R5
    irq_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        backup_o |-> !irq_wake_o);

    // R6
    wdt_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (backup_o && wdt_req_i && !(lv_sync && pin_ok)) |=> !sys_rst_o);

    // R7
    hold_backup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (backup_o && !(lv_sync && pin_ok)) |=> backup_o);

    // R3
    lv_fall_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lv_sync) && !backup_o) |=> backup_o);

    // R8
    release_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(backup_o) |-> (sys_rst_o && osc_en_o));

    // R8
    pulse_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |-> (hi_cnt < CW'(PULSE_CYCLES)));

    // R8
    pulse_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sys_rst_o) && !backup_o) |-> (hi_cnt == CW'(PULSE_CYCLES)));
endmodule

bind lvbk_ctrl lvbk_ctrl_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lv_sync    (lv_sync),
    .pin_ok     (pin_ok),
    .wdt_req_i  (wdt_req_i),
    .osc_en_o   (osc_en_o),
    .sys_rst_o  (sys_rst_o),
    .backup_o   (backup_o),
    .irq_wake_o (irq_wake_o)
);

// File: tb/lvbk_ctrl_tb.sv
module lvbk_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n, lv_ok, pin_n, irq, wdt;
    logic osc_en, sys_rst, backup, irq_wake;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    lvbk_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .lv_ok_i     (lv_ok),
        .ext_rst_n_i (pin_n),
        .irq_req_i   (irq),
        .wdt_req_i   (wdt),
        .osc_en_o    (osc_en),
        .sys_rst_o   (sys_rst),
        .backup_o    (backup),
        .irq_wake_o  (irq_wake)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_state(input string req, input int eb, input int eo, input int er);
        check(backup == eb, {req, " backup"}, backup, eb);
        check(osc_en == eo, {req, " osc_en"}, osc_en, eo);
        check(sys_rst == er, {req, " sys_rst"}, sys_rst, er);
    endtask

    // Count the high cycles of sys_rst, starting in a cycle where it is high.
    task automatic pulse_width(input string req);
        int w = 0;
        while (sys_rst && w < 100) begin
            check(osc_en == 1, {req, " osc_en during pulse"}, osc_en, 1);
            w++;
            step(1);
        end
        check(w == 16, {req, " pulse width"}, w, 16);
        check_state({req, " after pulse"}, 0, 1, 0);
    endtask

    // R1: reset state.
    task automatic t_reset();
        rst_n = 0; lv_ok = 0; pin_n = 0; irq = 1; wdt = 0;
        step(3);
        check_state("R1 in reset", 1, 0, 0);
        check(irq_wake == 0, "R1 irq_wake", irq_wake, 0);
        rst_n = 1;
        step(1);
        check_state("R1 after reset", 1, 0, 0);
        irq = 0;
    endtask

    // R7 then R8: pin good alone holds backup; supply rise releases.
    task automatic t_power_up();
        pin_n = 1;
        step(12);
        check_state("R7 pin only", 1, 0, 0);
        lv_ok = 1;
        step(2);
        check(backup == 1, "R8 latency hold", backup, 1);
        step(1);
        check_state("R8 release", 0, 1, 1);
        pulse_width("R8");
    endtask

    // R5: interrupt pass-through in run.
    task automatic t_irq_run();
        irq = 1;
        #1;
        check(irq_wake == 1, "R5 run pass", irq_wake, 1);
        irq = 0;
        #1;
        check(irq_wake == 0, "R5 run idle", irq_wake, 0);
    endtask

    // R6: watchdog in run gives a full pulse.
    task automatic t_wdt_run();
        wdt = 1;
        step(1);
        wdt = 0;
        check_state("R6 wdt run", 0, 1, 1);
        pulse_width("R6");
    endtask

    // R3, R4, R5, R6, R7: supply drop, blocked wakes, one-sided recovery.
    task automatic t_lv_drop();
        lv_ok = 0;
        step(2);
        check(backup == 0, "R3 before edge 3", backup, 0);
        step(1);
        check_state("R3 R4 entered", 1, 0, 0);
        irq = 1;
        #1;
        check(irq_wake == 0, "R5 blocked", irq_wake, 0);
        irq = 0;
        wdt = 1;
        for (int i = 0; i < 5; i++) begin
            step(1);
            check(sys_rst == 0 && osc_en == 0, "R6 wdt ignored", sys_rst, 0);
        end
        wdt = 0;
        pin_n = 0;
        step(10);
        lv_ok = 1;
        step(10);
        check_state("R7 supply only", 1, 0, 0);
        pin_n = 1;
        step(6);
        check(backup == 1, "R2 release cycle 6", backup, 1);
        step(1);
        check_state("R2 R8 release cycle 7", 0, 1, 1);
        pulse_width("R8 pin release");
    endtask

    // R2: short glitch ignored, held low enters backup after 7 cycles.
    task automatic t_pin();
        pin_n = 0;
        step(3);
        pin_n = 1;
        step(12);
        check_state("R2 glitch ignored", 0, 1, 0);
        pin_n = 0;
        step(6);
        check(backup == 0, "R2 entry cycle 6", backup, 0);
        step(1);
        check_state("R2 entry cycle 7", 1, 0, 0);
        pin_n = 1;
        step(7);
        check_state("R8 re-release", 0, 1, 1);
        pulse_width("R8 re-release");
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        step(1);
        t_reset();
        t_power_up();
        t_irq_run();
        t_wdt_run();
        t_lv_drop();
        t_pin();
        summary();
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end
endmodule